// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Block

This block holds a 32-bit interrupt cause register together with three mask registers: one for the CPU interrupt line, one for the PCI interrupt line, and one for system-error reporting. Hardware event pulses on `evt_in` set cause bits 31:1 on the clock edge. Software acknowledges an event by writing the cause register. A written 0 clears the matching bit and a written 1 leaves it as it was.

Bit 0 of the cause register cannot be written. It always shows whether any of bits 31:1 is set, so a handler can test one bit first. Each interrupt output is the OR, over bits 31:1, of the cause bits ANDed with that output's mask. Both outputs are registered and change on the same edge as the cause and mask registers. Each mask register stores only its own fixed set of writable bits.

Top module: `irq_cause_mask`

## Requirements
- R1: While `rst` is high at a clock edge, the cause register and all three masks become 0, and `cpu_irq` and `pci_irq` become 0.
- R2: A write to the cause register (`wr_addr` = 0) sets bits 31:1 to old AND written data. Writing 1 keeps a bit and writing 0 clears it.
- R3: Cause bit 0 equals the OR of cause bits 31:1 after every update. The value written to bit 0 has no effect.
- R4: A 1 on `evt_in[k]` (k from 1 to 31) sets cause bit k at that clock edge, and bit 0 follows in the same cycle. With no write, the other bits keep their values. `evt_in[0]` is ignored.
- R5: If an event and a software write that clears the same bit occur in the same cycle, the event wins and the bit reads as 1.
- R6: The CPU mask (`wr_addr` = 1) stores only the bits of the written data selected by 0x3C3FFFFE. All other bits read as 0.
- R7: The PCI mask (`wr_addr` = 2) stores only the bits selected by 0x03FFFFFE.
- R8: The system-error mask (`wr_addr` = 3) stores only bits 5:0.
- R9: `cpu_irq` is the OR over bits 31:1 of (cause AND CPU mask). It updates on the same edge as the registers.
- R10: `pci_irq` is the OR over bits 31:1 of (cause AND PCI mask). It updates on the same edge as the registers.
- R11: `rd_data` is registered. After a clock edge it shows the value that the register selected by `rd_addr` held just before that edge. The select codes are the same as for writes: 0 cause, 1 CPU mask, 2 PCI mask, 3 system-error mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | 32 | Registered read data |
| evt_in | input | 32 | Event pulses; bits 31:1 set cause bits, bit 0 unused |
| cpu_irq | output | 1 | CPU interrupt request |
| pci_irq | output | 1 | PCI interrupt request |

## Verification
A corrupted cause bit shows at the ports in one of two ways. It can show as an interrupt line that disagrees with cause AND mask on the very edge where the fault occurs. It can also show as a bit-0 summary that disagrees with the upper bits, one cycle later through the registered read port. A mask register that keeps a bit outside its writable pattern shows in a readback one cycle after the write. It also shows as an interrupt line that rises when the cause bit outside the pattern is set. The stimulus places a set and a clear on the same bit in one cycle, sets bits that lie outside the masks, and uses summary-only states in which both lines stay low, so that each of these faults can reach a port.

// File: rtl/irq_cm_pkg.sv
package irq_cm_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SEL_CAUSE     = 2'd0,
    SEL_CPU_MASK  = 2'd1,
    SEL_PCI_MASK  = 2'd2,
    SEL_SERR_MASK = 2'd3
  } reg_sel_e;

  localparam logic [REG_W-1:0] CPU_MASK_BITS  = 32'h3C3F_FFFE;
  localparam logic [REG_W-1:0] PCI_MASK_BITS  = 32'h03FF_FFFE;
  localparam logic [REG_W-1:0] SERR_MASK_BITS = 32'h0000_003F;
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt,
  output logic [DW-1:0] q,
  output logic [DW-1:0] nxt
);
  logic [DW-2:0] upper_kept;
  logic [DW-2:0] upper_nxt;

  always_comb begin
    upper_kept = clr_we ? (q[DW-1:1] & wdata[DW-1:1]) : q[DW-1:1];
    upper_nxt  = upper_kept | evt[DW-1:1];
    nxt        = {upper_nxt, |upper_nxt};
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int            DW    = 32,
  parameter logic [DW-1:0] WMASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q,
  output logic [DW-1:0] nxt
);
  always_comb nxt = we ? (wdata & WMASK) : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cause_nxt,
  input  logic [DW-1:0] mask_nxt,
  output logic          irq
);
  logic hit;
  always_comb hit = |(cause_nxt[DW-1:1] & mask_nxt[DW-1:1]);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= hit;
  end
endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask
  import irq_cm_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] evt_in,
  output logic          cpu_irq,
  output logic          pci_irq
);
  localparam int NMASK = 3;
  localparam logic [DW-1:0] MASK_BITS [NMASK] = '{CPU_MASK_BITS, PCI_MASK_BITS, SERR_MASK_BITS};

  logic [DW-1:0] cause_q, cause_nxt;
  logic [DW-1:0] mask_q   [NMASK];
  logic [DW-1:0] mask_nxt [NMASK];
  logic [DW-1:0] cpu_mask_q, pci_mask_q;

  irq_cause_reg #(.DW(DW)) u_cause (
    .clk    (clk),
    .rst    (rst),
    .clr_we (wr_en && (wr_addr == SEL_CAUSE)),
    .wdata  (wr_data),
    .evt    (evt_in),
    .q      (cause_q),
    .nxt    (cause_nxt)
  );

  for (genvar g = 0; g < NMASK; g++) begin : g_mask
    irq_mask_reg #(.DW(DW), .WMASK(MASK_BITS[g])) u_mask (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en && (wr_addr == 2'(g + 1))),
      .wdata (wr_data),
      .q     (mask_q[g]),
      .nxt   (mask_nxt[g])
    );
  end

  assign cpu_mask_q = mask_q[0];
  assign pci_mask_q = mask_q[1];

  irq_line #(.DW(DW)) u_cpu_line (
    .clk (clk), .rst (rst),
    .cause_nxt (cause_nxt), .mask_nxt (mask_nxt[0]),
    .irq (cpu_irq)
  );

  irq_line #(.DW(DW)) u_pci_line (
    .clk (clk), .rst (rst),
    .cause_nxt (cause_nxt), .mask_nxt (mask_nxt[1]),
    .irq (pci_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        SEL_CAUSE:     rd_data <= cause_q;
        SEL_CPU_MASK:  rd_data <= mask_q[0];
        SEL_PCI_MASK:  rd_data <= mask_q[1];
        default:       rd_data <= mask_q[2];
      endcase
    end
  end
endmodule

// File: rtl/irq_cause_mask_chk.sv
module irq_cause_mask_chk
  import irq_cm_pkg::*;
#(
  parameter int DW = REG_W
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [1:0]    rd_addr,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] evt_in,
  input logic          cpu_irq,
  input logic          pci_irq,
  input logic [DW-1:0] cause_q,
  input logic [DW-1:0] cpu_mask_q,
  input logic [DW-1:0] pci_mask_q
);
  localparam logic [DW-1:0] UPPER = {{(DW-1){1'b1}}, 1'b0};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cause_q == '0 && cpu_mask_q == '0 && !cpu_irq && !pci_irq));

  assert_write_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0 && (evt_in & UPPER) == '0)
    |=> ((cause_q & UPPER) == ($past(cause_q) & $past(wr_data) & UPPER)));

  assert_summary_read_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == 2'd0) |=> (rd_data[0] == |rd_data[DW-1:1]));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (rst)
    ((evt_in & UPPER) != '0)
    |=> ((cause_q & $past(evt_in) & UPPER) == ($past(evt_in) & UPPER)));

  assert_cpu_mask_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_mask_q & ~CPU_MASK_BITS) == '0);

  assert_cpu_line_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == |(cause_q & cpu_mask_q & UPPER));

  assert_pci_line_R10: assert property (@(posedge clk) disable iff (rst)
    pci_irq == |(cause_q & pci_mask_q & UPPER));
endmodule

bind irq_cause_mask irq_cause_mask_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .evt_in     (evt_in),
  .cpu_irq    (cpu_irq),
  .pci_irq    (pci_irq),
  .cause_q    (cause_q),
  .cpu_mask_q (cpu_mask_q),
  .pci_mask_q (pci_mask_q)
);

// File: tb/irq_cause_mask_test.sv
`timescale 1ns/1ps
module irq_cause_mask_test;
  localparam int DW = 32;
  localparam int NVEC = 14;
  // row: {addr[1:0], data[31:0], evt[31:0], expected readback[31:0], cpu_irq, pci_irq}
  localparam logic [99:0] VEC [NVEC] = '{
    {2'd1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h3C3F_FFFE, 1'b0, 1'b0}, // R6
    {2'd2, 32'hFFFF_FFFF, 32'h0000_0000, 32'h03FF_FFFE, 1'b0, 1'b0}, // R7
    {2'd3, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_003F, 1'b0, 1'b0}, // R8
    {2'd0, 32'hFFFF_FFFF, 32'h0000_0010, 32'h0000_0011, 1'b1, 1'b1}, // R4 R9 R10
    {2'd0, 32'hFFFF_FFFF, 32'h4000_0000, 32'h4000_0011, 1'b1, 1'b1}, // R2 keep
    {2'd0, 32'hFFFF_FFEF, 32'h0000_0000, 32'h4000_0001, 1'b0, 1'b0}, // R2 clear, R3
    {2'd1, 32'h4000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}, // R6
    {2'd0, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}, // R3 bit0 write
    {2'd0, 32'h0000_0000, 32'h0400_0000, 32'h0400_0001, 1'b0, 1'b0}, // R5
    {2'd1, 32'h0400_0000, 32'h0000_0000, 32'h0400_0000, 1'b1, 1'b0}, // R9
    {2'd2, 32'h0200_0000, 32'h0000_0000, 32'h0200_0000, 1'b1, 1'b0}, // R7
    {2'd0, 32'hFFFF_FFFF, 32'h0200_0000, 32'h0600_0001, 1'b1, 1'b1}, // R10
    {2'd0, 32'hFBFF_FFFF, 32'h0000_0000, 32'h0200_0001, 1'b0, 1'b1}, // R2
    {2'd0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}  // R2
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] evt_in = '0;
  logic          cpu_irq, pci_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_cause_mask uut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
    .evt_in (evt_in), .cpu_irq (cpu_irq), .pci_irq (pci_irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [DW-1:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic pulse(input logic w, input logic [1:0] a, input logic [DW-1:0] d,
                       input logic [DW-1:0] e);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; evt_in = e; rd_addr = a;
    @(negedge clk);
    wr_en = 1'b0; evt_in = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      read_reg(2'(a), v);
      check("R1 reset readback", v, '0);
    end
    check("R1 cpu_irq", {31'd0, cpu_irq}, 32'd0);
    check("R1 pci_irq", {31'd0, pci_irq}, 32'd0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      pulse(1'b1, VEC[i][99:98], VEC[i][97:66], VEC[i][65:34]);
      check($sformatf("R9 cpu_irq row %0d", i), {31'd0, cpu_irq}, {31'd0, VEC[i][1]});
      check($sformatf("R10 pci_irq row %0d", i), {31'd0, pci_irq}, {31'd0, VEC[i][0]});
      @(negedge clk);
      check($sformatf("R2 R3 R6 readback row %0d", i), rd_data, VEC[i][33:2]);
    end

    // R4: event only, no write; evt_in[0] ignored
    pulse(1'b0, 2'd0, '0, 32'h0000_0009);
    @(negedge clk);
    check("R4 event-only set", rd_data, 32'h0000_0009);
    check("R4 cpu_irq unmasked bit", {31'd0, cpu_irq}, 32'd0);
    pulse(1'b0, 2'd0, '0, 32'h0200_0000);
    check("R10 pci_irq on event", {31'd0, pci_irq}, 32'd1);
    @(negedge clk);
    check("R4 second event keeps first", rd_data, 32'h0200_0009);

    // R11: read latency of one edge
    read_reg(2'd2, v);
    check("R11 pci mask read", v, 32'h0200_0000);
    rd_addr = 2'd1;
    #1;
    check("R11 before edge holds old", rd_data, 32'h0200_0000);
    @(negedge clk);
    check("R11 after edge new select", rd_data, 32'h0400_0000);

    // R1: reset in mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 cpu_irq after reset", {31'd0, cpu_irq}, 32'd0);
    check("R1 pci_irq after reset", {31'd0, pci_irq}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      read_reg(2'(a), v);
      check("R1 mid-run reset readback", v, '0);
    end

    done = 1'b1;
    finish_run();
  end
endmodule